// File: doc/BRIEF.md
# Raster Timing Generator

The raster timing generator produces the horizontal and vertical timing of a non-interlaced display, one pixel per clock. Three 32-bit setup words program it. The horizontal word holds four fields that count groups of four pixels. The vertical word holds four fields that count scan lines. The base word gives the row where the displayed image starts in frame memory, in 4096-byte units.

Each line runs through the active region, the front porch, the sync pulse and the back porch, in that order. A frame runs through the same four regions, counted in lines. The block drives active-low horizontal and vertical syncs, and a composite sync suitable for carrying on the green signal. It also drives a blanking flag, the current column and line, and the byte address of the current pixel in frame memory at 8 bits per pixel. The line pitch equals the active width in pixels.

Software writes the setup words through a simple register port at any time. The timing logic works from shadow copies, which are loaded only at a frame boundary, so a frame is never built from mixed settings.

Top module: `raster_gen`

## Requirements
- R1: Writing with `reg_wr_i` high stores `reg_wdata_i` at the rising edge into the word selected by `reg_addr_i`: 0 is the horizontal word, 1 is the vertical word and 2 is the base word. All 32 bits of each word read back on `reg_rdata_o` combinationally, and address 3 reads as zero.
- R2: The horizontal word has these fields: active in bits 8:0, front porch in bits 13:9, sync in bits 20:14 and back porch in bits 27:21. Each field counts 4 pixels. A line is active, front porch, sync, back porch, and a zero field takes no clocks. If all four fields are zero, every clock starts a new line.
- R3: `hsync_no` is low exactly during the horizontal sync pixels of every line.
- R4: The vertical word has these fields, all in lines: active in bits 10:0, front porch in bits 15:11, sync in bits 21:16 and back porch in bits 27:22. They follow the same order as a line. `vsync_no` is low for whole lines inside the vertical sync region.
- R5: `blank_o` is low only when both the column and the line lie in their active regions.
- R6: `col_o` counts pixels from 0 at the first active pixel and steps by one each clock. `line_o` counts lines from 0 and steps when the column wraps to 0.
- R7: `fetch_addr_o` equals base[8:0] × 4096 + line × (horizontal active × 4) + column, taken modulo 2^FB_AW.
- R8: `csync_no` is low when exactly one of the horizontal and vertical syncs is asserted, and high otherwise.
- R9: New setup values reach the timing only at the first clock of the next frame. A write made in the last clock of a frame applies to the frame that follows it.
- R10: During and right after reset, the column and line are 0 and the setup words hold the parameter defaults, which also drive the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| csync_no | output | 1 | Composite sync for sync-on-green, active low |
| blank_o | output | 1 | High outside the active picture |
| col_o | output | 12 | Current pixel column |
| line_o | output | 12 | Current scan line |
| fetch_addr_o | output | 24 | Frame-memory byte address of the current pixel |

## Verification
The assertions check the following on every cycle:
- The column steps by one each clock, and the line changes only when the column is 0.
- The vertical sync changes only at a line start.
- Any sync lies inside the blanking interval.
- The fetch address rises by one along an active line.
- The shadow copies change only at position (0,0).
- The composite sync stays high while both syncs agree.

Some behaviours need the bench, which runs a reference model. Only the bench can show the exact segment lengths decoded from each field, the effect of zero-length fields, write forwarding in the last clock of a frame, the register readback, and the absolute fetch address.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 2;
  localparam int NREG      = 3;
  localparam int BASE_W    = 9;
  localparam int CNT_W     = 12;  // holds (511+31+127+127)*4 and 2047+31+63+63
  localparam int GRP_SHIFT = 2;   // horizontal fields count 4-pixel groups

  typedef struct packed {
    logic [6:0] bp;
    logic [6:0] sy;
    logic [4:0] fp;
    logic [8:0] act;
  } hor_t;

  typedef struct packed {
    logic [5:0]  bp;
    logic [5:0]  sy;
    logic [4:0]  fp;
    logic [10:0] act;
  } ver_t;

  localparam int SETUP_W = $bits(hor_t);
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_HOR  = '0,
  parameter logic [REG_W-1:0] DEF_VER  = '0,
  parameter logic [REG_W-1:0] DEF_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              load_i,
  output logic [REG_W-1:0]  rdata_o,
  output hor_t              sh_hor_o,
  output ver_t              sh_ver_o,
  output logic [BASE_W-1:0] sh_base_o
);
  localparam logic [REG_W-1:0] RST_V [NREG] = '{DEF_HOR, DEF_VER, DEF_BASE};

  logic [REG_W-1:0] regs_q [NREG];
  logic [NREG-1:0]  sel;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign sel[i] = wr_i && (addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[i] <= RST_V[i];
      else if (sel[i]) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  // Shadow load forwards a write landing on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_hor_o  <= hor_t'(DEF_HOR[SETUP_W-1:0]);
      sh_ver_o  <= ver_t'(DEF_VER[SETUP_W-1:0]);
      sh_base_o <= DEF_BASE[BASE_W-1:0];
    end else if (load_i) begin
      sh_hor_o  <= hor_t'(sel[0] ? wdata_i[SETUP_W-1:0] : regs_q[0][SETUP_W-1:0]);
      sh_ver_o  <= ver_t'(sel[1] ? wdata_i[SETUP_W-1:0] : regs_q[1][SETUP_W-1:0]);
      sh_base_o <= sel[2] ? wdata_i[BASE_W-1:0] : regs_q[2][BASE_W-1:0];
    end
  end
endmodule

// File: rtl/raster_axis.sv
module raster_axis #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [CW-1:0] len_act_i,
  input  logic [CW-1:0] len_fp_i,
  input  logic [CW-1:0] len_sy_i,
  input  logic [CW-1:0] len_bp_i,
  output logic [CW-1:0] pos_o,
  output logic          active_o,
  output logic          sync_o,
  output logic          wrap_o
);
  logic [CW-1:0] end_fp, end_sy, total;
  logic          last;

  assign end_fp   = len_act_i + len_fp_i;
  assign end_sy   = end_fp + len_sy_i;
  assign total    = end_sy + len_bp_i;
  assign last     = (total == '0) || (pos_o == total - 1'b1);
  assign active_o = pos_o < len_act_i;
  assign sync_o   = (pos_o >= end_fp) && (pos_o < end_sy);
  assign wrap_o   = adv_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_o <= '0;
    else if (adv_i) pos_o <= last ? '0 : pos_o + 1'b1;
  end
endmodule

// File: rtl/raster_gen.sv
module raster_gen
  import raster_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_HOR   = 32'h0292_83A0,
  parameter logic [REG_W-1:0] DEF_VER   = 32'h0082_09E0,
  parameter logic [REG_W-1:0] DEF_BASE  = 32'h0000_0000,
  parameter int               ROW_SHIFT = 12,
  parameter int               FB_AW     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              hsync_no,
  output logic              vsync_no,
  output logic              csync_no,
  output logic              blank_o,
  output logic [CNT_W-1:0]  col_o,
  output logic [CNT_W-1:0]  line_o,
  output logic [FB_AW-1:0]  fetch_addr_o
);
  localparam int CW = CNT_W;

  hor_t              sh_hor;
  ver_t              sh_ver;
  logic [BASE_W-1:0] sh_base;
  logic              h_act, h_sync, h_wrap;
  logic              v_act, v_sync, v_wrap;
  logic [CW-1:0]     h_pos, v_pos, h_len_act;
  logic              frame_end;

  assign frame_end = h_wrap && v_wrap;
  assign h_len_act = CW'({sh_hor.act, {GRP_SHIFT{1'b0}}});

  raster_regs #(
    .DEF_HOR (DEF_HOR),
    .DEF_VER (DEF_VER),
    .DEF_BASE(DEF_BASE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .load_i   (frame_end),
    .rdata_o  (reg_rdata_o),
    .sh_hor_o (sh_hor),
    .sh_ver_o (sh_ver),
    .sh_base_o(sh_base)
  );

  raster_axis #(.CW(CW)) u_hax (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (1'b1),
    .len_act_i(h_len_act),
    .len_fp_i (CW'({sh_hor.fp, {GRP_SHIFT{1'b0}}})),
    .len_sy_i (CW'({sh_hor.sy, {GRP_SHIFT{1'b0}}})),
    .len_bp_i (CW'({sh_hor.bp, {GRP_SHIFT{1'b0}}})),
    .pos_o    (h_pos),
    .active_o (h_act),
    .sync_o   (h_sync),
    .wrap_o   (h_wrap)
  );

  raster_axis #(.CW(CW)) u_vax (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (h_wrap),
    .len_act_i(CW'(sh_ver.act)),
    .len_fp_i (CW'(sh_ver.fp)),
    .len_sy_i (CW'(sh_ver.sy)),
    .len_bp_i (CW'(sh_ver.bp)),
    .pos_o    (v_pos),
    .active_o (v_act),
    .sync_o   (v_sync),
    .wrap_o   (v_wrap)
  );

  assign hsync_no = ~h_sync;
  assign vsync_no = ~v_sync;
  assign csync_no = ~(h_sync ^ v_sync);
  assign blank_o  = ~(h_act && v_act);
  assign col_o    = h_pos;
  assign line_o   = v_pos;

  // 8 bpp: line pitch in bytes equals active width in pixels
  assign fetch_addr_o = FB_AW'({sh_base, {ROW_SHIFT{1'b0}}})
                      + FB_AW'(v_pos) * FB_AW'(h_len_act)
                      + FB_AW'(h_pos);
endmodule

// File: rtl/raster_gen_chk.sv
module raster_gen_chk
  import raster_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          csync_no,
  input logic          blank_o,
  input logic [CW-1:0] col_o,
  input logic [CW-1:0] line_o,
  input logic [AW-1:0] fetch_addr_o,
  input hor_t          sh_hor,
  input ver_t          sh_ver
);
  a_r6_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o != '0) |-> (col_o == $past(col_o) + 1'b1));

  a_r6_line_at_col0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> (col_o == '0));

  a_r4_vsync_line_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_no) |-> (col_o == '0));

  a_r5_sync_blanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_no || !vsync_no) |-> blank_o);

  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_o && !$past(blank_o) && col_o != '0) |->
      (fetch_addr_o == $past(fetch_addr_o) + 1'b1));

  a_r8_csync_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_no == vsync_no) |-> csync_no);

  a_r9_shadow_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sh_hor) || !$stable(sh_ver)) |-> (col_o == '0 && line_o == '0));
endmodule

bind raster_gen raster_gen_chk #(.CW(raster_pkg::CNT_W), .AW(FB_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsync_no    (hsync_no),
  .vsync_no    (vsync_no),
  .csync_no    (csync_no),
  .blank_o     (blank_o),
  .col_o       (col_o),
  .line_o      (line_o),
  .fetch_addr_o(fetch_addr_o),
  .sh_hor      (sh_hor),
  .sh_ver      (sh_ver)
);

// File: tb/raster_gen_tb_top.sv
`timescale 1ns/1ps
module raster_gen_tb_top;
  localparam int AW = 24;
  localparam logic [31:0] H0 = 32'(4 | (1 << 9) | (2 << 14) | (1 << 21));
  localparam logic [31:0] V0 = 32'(3 | (1 << 11) | (2 << 16) | (1 << 22));
  localparam logic [31:0] B0 = 32'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hsync_n, vsync_n, csync_n, blank;
  logic [11:0] col, line;
  logic [AW-1:0] faddr;

  int chk = 0;
  int err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  raster_gen #(.DEF_HOR(H0), .DEF_VER(V0), .DEF_BASE(B0), .FB_AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hsync_no(hsync_n),
    .vsync_no(vsync_n), .csync_no(csync_n), .blank_o(blank), .col_o(col),
    .line_o(line), .fetch_addr_o(faddr)
  );

  // Reference model built from the requirements
  logic [31:0] m_reg [3];
  logic [31:0] s_hor, s_ver, s_base;
  int mh, mv;

  function automatic int hlen(logic [31:0] r, int k);
    case (k)
      0: return 4 * int'(r[8:0]);
      1: return 4 * int'(r[13:9]);
      2: return 4 * int'(r[20:14]);
      default: return 4 * int'(r[27:21]);
    endcase
  endfunction

  function automatic int vlen(logic [31:0] r, int k);
    case (k)
      0: return int'(r[10:0]);
      1: return int'(r[15:11]);
      2: return int'(r[21:16]);
      default: return int'(r[27:22]);
    endcase
  endfunction

  function automatic int htot();
    return hlen(s_hor,0) + hlen(s_hor,1) + hlen(s_hor,2) + hlen(s_hor,3);
  endfunction
  function automatic int vtot();
    return vlen(s_ver,0) + vlen(s_ver,1) + vlen(s_ver,2) + vlen(s_ver,3);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] <= H0; m_reg[1] <= V0; m_reg[2] <= B0;
      s_hor <= H0; s_ver <= V0; s_base <= B0;
      mh <= 0; mv <= 0;
    end else begin
      if (reg_wr && reg_addr != 2'd3) m_reg[reg_addr] <= reg_wdata;
      if (htot() == 0 || mh == htot() - 1) begin
        mh <= 0;
        if (vtot() == 0 || mv == vtot() - 1) begin
          mv <= 0;
          s_hor  <= (reg_wr && reg_addr == 2'd0) ? reg_wdata : m_reg[0];
          s_ver  <= (reg_wr && reg_addr == 2'd1) ? reg_wdata : m_reg[1];
          s_base <= (reg_wr && reg_addr == 2'd2) ? reg_wdata : m_reg[2];
        end else mv <= mv + 1;
      end else mh <= mh + 1;
    end
  end

  task automatic compare_outputs(string tag);
    bit bad = 0;
    int ha = hlen(s_hor,0), hf = hlen(s_hor,1), hs = hlen(s_hor,2);
    int va = vlen(s_ver,0), vf = vlen(s_ver,1), vs = vlen(s_ver,2);
    bit hsl = (mh >= ha + hf) && (mh < ha + hf + hs);
    bit vsl = (mv >= va + vf) && (mv < va + vf + vs);
    bit eb  = !((mh < ha) && (mv < va));
    int ea  = (int'(s_base[8:0]) * 4096 + mv * ha + mh) & ((1 << AW) - 1);
    chk++;
    if (hsync_n !== !hsl) begin bad = 1;
      $display("FAIL R2/R3 %s hsync_no act=%b exp=%b", tag, hsync_n, !hsl); end
    if (vsync_n !== !vsl) begin bad = 1;
      $display("FAIL R4 %s vsync_no act=%b exp=%b", tag, vsync_n, !vsl); end
    if (csync_n !== (hsl == vsl)) begin bad = 1;
      $display("FAIL R8 %s csync_no act=%b exp=%b", tag, csync_n, hsl == vsl); end
    if (blank !== eb) begin bad = 1;
      $display("FAIL R5 %s blank_o act=%b exp=%b", tag, blank, eb); end
    if (int'(col) != mh || int'(line) != mv) begin bad = 1;
      $display("FAIL R6 %s col/line act=%0d/%0d exp=%0d/%0d", tag, col, line, mh, mv); end
    if (int'(faddr) != ea) begin bad = 1;
      $display("FAIL R7 %s fetch_addr act=%0h exp=%0h", tag, faddr, ea); end
    if (bad) err++;
  endtask

  task automatic tick(string tag);
    @(posedge clk); @(negedge clk);
    compare_outputs(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic write_reg(logic [1:0] a, logic [31:0] d, string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(tag);
    reg_wr = 1'b0;
  endtask

  task automatic read_check(logic [1:0] a, logic [31:0] exp, string tag);
    reg_addr = a; #1;
    chk++;
    if (reg_rdata !== exp) begin
      err++;
      $display("FAIL %s readback addr %0d act=%h exp=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk++;
    if (col !== '0 || line !== '0 || blank !== 1'b0 || hsync_n !== 1'b1 ||
        vsync_n !== 1'b1 || faddr !== AW'(5 * 4096)) begin
      err++;
      $display("FAIL R10 reset outputs act col=%0d line=%0d blank=%b addr=%0h exp 0/0/0/%0h",
               col, line, blank, faddr, 5 * 4096);
    end
    read_check(2'd0, H0, "R10");
    read_check(2'd1, V0, "R10");
    read_check(2'd2, B0, "R10");
    rst_n = 1'b1;
    compare_outputs("R10 release");
  endtask

  task automatic t_default_frames();
    run(3 * 224 + 17, "R2 default");
  endtask

  task automatic t_readback();
    write_reg(2'd2, 32'hFFFF_FE07, "R1");
    read_check(2'd2, 32'hFFFF_FE07, "R1");
    write_reg(2'd1, 32'hF000_0000 | V0, "R1");
    read_check(2'd1, 32'hF000_0000 | V0, "R1");
    read_check(2'd3, 32'h0, "R1");
    run(2 * 224, "R1 R7 base");
  endtask

  task automatic t_midframe();
    run(50, "R9 pre");
    write_reg(2'd0, 32'(6 | (2 << 9) | (3 << 14) | (2 << 21)), "R9 mid");
    run(2 * 7 * 52 + 30, "R9 mid");
  endtask

  task automatic t_lastcycle();
    while (!(mh == htot() - 1 && mv == vtot() - 1)) tick("R9 seek");
    write_reg(2'd1, 32'(2 | (1 << 11) | (1 << 16) | (2 << 22)), "R9 last");
    run(2 * 6 * 52 + 10, "R9 last");
  endtask

  task automatic t_zero_fields();
    write_reg(2'd0, 32'(3 | (2 << 14)), "R2 zero");
    write_reg(2'd1, 32'(2 | (1 << 16)), "R4 zero");
    run(3 * 3 * 20 + 60, "R2 R4 zero");
    write_reg(2'd0, 32'h0, "R2 allzero");
    run(40, "R2 allzero");
    write_reg(2'd0, 32'((1 << 9) | (1 << 14)), "R5 noactive");
    run(60, "R5 noactive");
  endtask

  initial begin
    t_reset();
    t_default_frames();
    t_readback();
    t_midframe();
    t_lastcycle();
    t_zero_fields();
    done = 1;
    $display("Result: errors=%0d of %0d checks", err, chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      err++; chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", err, chk);
      $finish;
    end
  end
endmodule